// File: doc/BRIEF.md
# Servo Cell Timing Generator

This block produces the per-cell strobes of a dedicated-servo disc channel from a reference clock derived from the write clock. A cell counter runs through a fixed number of reference clocks per servo cell. From that count the block decodes two strobes for the position demodulator: an A sample and a B sample. It also decodes a two-clock dump pulse that clears the peak detectors once sampling is done. For the mark decoder it makes three more strobes: a cell sampling clock, a threshold strobe and a decoder clock.

A servo controller steers the pattern with three mode inputs. Guard-band enable picks guard-band-mark search instead of sector-mark search, and in that mode the sampling clock fires twice per cell. Quadrature select moves the A/B strobes from the in-phase dibit pair to the quad pair. The LSB input swaps the A and B strobes on alternate tracks. The mode inputs are captured only at a cell boundary, so a cell never mixes two patterns. A guard-band-detect flag from the mark decoder goes back to the controller, registered once.

Top module: `servo_cell_timer`

## Requirements
- R1: The cell counter counts 0 to 15 and wraps to 0. When cell_start is high at a clock edge, the next cycle is count 0 and a new cell begins.
- R2: With quad_sel and lsb_in both captured low, samp_a is high at count 3 and samp_b is high at count 7.
- R3: With quad_sel captured high and lsb_in captured low, samp_a is high at count 7 and samp_b is high at count 11.
- R4: With lsb_in captured high, the positions of samp_a and samp_b are swapped. In-phase gives A at 7 and B at 3. Quad gives A at 11 and B at 7.
- R5: Each sample strobe lasts one clock, and samp_a and samp_b are never high together.
- R6: dump is high at counts 13 and 14, which makes a two-clock pulse. It is never high in the same cycle as a sample strobe.
- R7: zclk is high at count 0 when gb_en is captured low. It is high at counts 0 and 8 when gb_en is captured high.
- R8: thr_strb is high at count 5 and mdclk is high at count 15, whatever the captured gb_en.
- R9: gb_en, quad_sel and lsb_in are captured only at the clock edge that starts a cell, either the wrap from 15 or a cell_start. Changes at any other time have no effect on the current cell.
- R10: gbd_out equals the value gbd_in had one clock earlier.
- R11: While rst_n is low, every strobe output and gbd_out is low. The first cycle after reset is count 0 with all modes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock derived from the write clock |
| rst_n | input | 1 | Active-low reset |
| cell_start | input | 1 | Synchronous restart: the next cycle is count 0 |
| gb_en | input | 1 | Guard-band-mark search when high, sector-mark search when low |
| quad_sel | input | 1 | Quad dibit pair when high, in-phase pair when low |
| lsb_in | input | 1 | Track parity: high swaps the A and B strobes |
| gbd_in | input | 1 | Guard-band-detect flag from the mark decoder |
| samp_a | output | 1 | A sample-and-hold strobe |
| samp_b | output | 1 | B sample-and-hold strobe |
| dump | output | 1 | Peak-detector discharge pulse |
| zclk | output | 1 | Mark-decoder cell sampling clock |
| thr_strb | output | 1 | Mark-decoder threshold strobe |
| mdclk | output | 1 | Mark-decoder clock |
| gbd_out | output | 1 | Guard-band-detect flag to the controller |

## Verification
The checker runs on every cycle and covers the rules that hold in any mode:
- the A and B strobes never coincide and each lasts one clock;
- dump never overlaps a sample strobe and lasts two clocks;
- a decoder clock is always followed by a sampling clock, and the threshold strobe sits at its count;
- a cell_start always restarts the count;
- the captured mode changes only at a boundary;
- the detect flag trails its input by one clock.

Only the bench scenarios show that each mode puts the strobes at the right counts, that lsb_in swaps them, and that the second sampling clock appears only in guard-band search. The same scenarios show that mode changes mid-cell are ignored and that truncated cells restart cleanly.

// File: rtl/sct_pkg.sv
package sct_pkg;

   typedef struct packed {
      logic gb;
      logic quad;
      logic swap;
   } sct_mode_t;

   typedef struct packed {
      logic samp_a;
      logic samp_b;
      logic dump;
      logic zclk;
      logic thr;
      logic mdclk;
   } sct_strobe_t;

endpackage

// File: rtl/sct_cell_counter.sv
module sct_cell_counter #(
   parameter int CELL_LEN = 16,
   localparam int CW = $clog2(CELL_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cell_start,
   output logic [CW-1:0] cnt,
   output logic          boundary
);
   localparam logic [CW-1:0] LAST = CW'(CELL_LEN - 1);

   assign boundary = cell_start || (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (boundary) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sct_mode_latch.sv
module sct_mode_latch
   import sct_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  logic      gb_en,
   input  logic      quad_sel,
   input  logic      lsb_in,
   output sct_mode_t mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (load) begin
         mode.gb   <= gb_en;
         mode.quad <= quad_sel;
         mode.swap <= lsb_in;
      end
   end
endmodule

// File: rtl/sct_strobe_decode.sv
module sct_strobe_decode
   import sct_pkg::*;
#(
   parameter int CELL_LEN      = 16,
   parameter int IP_A_AT       = 3,
   parameter int IP_B_AT       = 7,
   parameter int QD_A_AT       = 7,
   parameter int QD_B_AT       = 11,
   parameter int DUMP_AT       = 13,
   parameter int DUMP_LEN      = 2,
   parameter int THR_AT        = 5,
   parameter int MD_AT         = 15,
   parameter int GB_ZCLK_MULT  = 2,
   localparam int CW           = $clog2(CELL_LEN),
   localparam int ZCLK_SPACING = CELL_LEN / GB_ZCLK_MULT
) (
   input  logic [CW-1:0] cnt,
   input  sct_mode_t     mode,
   output sct_strobe_t   strb
);
   logic [DUMP_LEN-1:0]     dump_hit;
   logic [GB_ZCLK_MULT-1:0] zclk_hit;
   logic [CW-1:0]           first_at;
   logic [CW-1:0]           second_at;
   logic                    first_hit;
   logic                    second_hit;

   for (genvar d = 0; d < DUMP_LEN; d++) begin : g_dump
      assign dump_hit[d] = (cnt == CW'(DUMP_AT + d));
   end

   for (genvar k = 0; k < GB_ZCLK_MULT; k++) begin : g_zclk
      assign zclk_hit[k] = (cnt == CW'(k * ZCLK_SPACING));
   end

   always_comb begin
      first_at    = mode.quad ? CW'(QD_A_AT) : CW'(IP_A_AT);
      second_at   = mode.quad ? CW'(QD_B_AT) : CW'(IP_B_AT);
      first_hit   = (cnt == first_at);
      second_hit  = (cnt == second_at);
      strb.samp_a = mode.swap ? second_hit : first_hit;
      strb.samp_b = mode.swap ? first_hit  : second_hit;
      strb.dump   = |dump_hit;
      strb.zclk   = mode.gb ? (|zclk_hit) : zclk_hit[0];
      strb.thr    = (cnt == CW'(THR_AT));
      strb.mdclk  = (cnt == CW'(MD_AT));
   end
endmodule

// File: rtl/servo_cell_timer.sv
module servo_cell_timer
   import sct_pkg::*;
#(
   parameter int CELL_LEN     = 16,
   parameter int IP_A_AT      = 3,
   parameter int IP_B_AT      = 7,
   parameter int QD_A_AT      = 7,
   parameter int QD_B_AT      = 11,
   parameter int DUMP_AT      = 13,
   parameter int DUMP_LEN     = 2,
   parameter int THR_AT       = 5,
   parameter int MD_AT        = 15,
   parameter int GB_ZCLK_MULT = 2,
   parameter bit REG_OUT      = 1'b0,
   localparam int CW          = $clog2(CELL_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cell_start,
   input  logic gb_en,
   input  logic quad_sel,
   input  logic lsb_in,
   input  logic gbd_in,
   output logic samp_a,
   output logic samp_b,
   output logic dump,
   output logic zclk,
   output logic thr_strb,
   output logic mdclk,
   output logic gbd_out
);
   logic [CW-1:0] cell_cnt;
   logic          boundary;
   sct_mode_t     mode;
   sct_strobe_t   strb;
   sct_strobe_t   strb_out;
   logic          gbd_q;

   if (CELL_LEN < 4) begin : g_bad_len
      $error("servo_cell_timer: CELL_LEN must be at least 4");
   end
   if (GB_ZCLK_MULT < 1 || (CELL_LEN % GB_ZCLK_MULT) != 0) begin : g_bad_mult
      $error("servo_cell_timer: GB_ZCLK_MULT must divide CELL_LEN");
   end
   if (DUMP_LEN < 1 || DUMP_AT + DUMP_LEN > CELL_LEN) begin : g_bad_dump
      $error("servo_cell_timer: dump window exceeds the cell");
   end
   if (IP_A_AT >= CELL_LEN || IP_B_AT >= CELL_LEN || QD_A_AT >= CELL_LEN ||
       QD_B_AT >= CELL_LEN || THR_AT >= CELL_LEN || MD_AT >= CELL_LEN) begin : g_bad_pos
      $error("servo_cell_timer: a strobe position lies outside the cell");
   end
   if (IP_A_AT == IP_B_AT || QD_A_AT == QD_B_AT) begin : g_bad_pair
      $error("servo_cell_timer: A and B strobes must use distinct counts");
   end
   if ((IP_A_AT >= DUMP_AT && IP_A_AT < DUMP_AT + DUMP_LEN) ||
       (IP_B_AT >= DUMP_AT && IP_B_AT < DUMP_AT + DUMP_LEN) ||
       (QD_A_AT >= DUMP_AT && QD_A_AT < DUMP_AT + DUMP_LEN) ||
       (QD_B_AT >= DUMP_AT && QD_B_AT < DUMP_AT + DUMP_LEN)) begin : g_bad_overlap
      $error("servo_cell_timer: a sample strobe falls inside the dump window");
   end

   sct_cell_counter #(
      .CELL_LEN (CELL_LEN)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_start (cell_start),
      .cnt        (cell_cnt),
      .boundary   (boundary)
   );

   sct_mode_latch u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (boundary),
      .gb_en    (gb_en),
      .quad_sel (quad_sel),
      .lsb_in   (lsb_in),
      .mode     (mode)
   );

   sct_strobe_decode #(
      .CELL_LEN     (CELL_LEN),
      .IP_A_AT      (IP_A_AT),
      .IP_B_AT      (IP_B_AT),
      .QD_A_AT      (QD_A_AT),
      .QD_B_AT      (QD_B_AT),
      .DUMP_AT      (DUMP_AT),
      .DUMP_LEN     (DUMP_LEN),
      .THR_AT       (THR_AT),
      .MD_AT        (MD_AT),
      .GB_ZCLK_MULT (GB_ZCLK_MULT)
   ) u_dec (
      .cnt  (cell_cnt),
      .mode (mode),
      .strb (strb)
   );

   // Detect flag back to the controller, one register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gbd_q <= 1'b0;
      end else begin
         gbd_q <= gbd_in;
      end
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            strb_out <= '0;
         end else begin
            strb_out <= strb;
         end
      end
   end else begin : g_comb_out
      assign strb_out = rst_n ? strb : '0;
   end

   assign samp_a   = strb_out.samp_a;
   assign samp_b   = strb_out.samp_b;
   assign dump     = strb_out.dump;
   assign zclk     = strb_out.zclk;
   assign thr_strb = strb_out.thr;
   assign mdclk    = strb_out.mdclk;
   assign gbd_out  = gbd_q;
endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
   parameter int CELL_LEN = 16,
   parameter int THR_AT   = 5,
   parameter bit REG_OUT  = 1'b0,
   localparam int CW      = $clog2(CELL_LEN)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cell_start,
   input logic          gbd_in,
   input logic          samp_a,
   input logic          samp_b,
   input logic          dump,
   input logic          zclk,
   input logic          thr_strb,
   input logic          mdclk,
   input logic          gbd_out,
   input logic [CW-1:0] cell_cnt,
   input logic          boundary,
   input logic [2:0]    mode
);
   logic past_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         past_valid <= 1'b0;
      end else begin
         past_valid <= 1'b1;
      end
   end

   assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cell_start |=> (cell_cnt == '0));

   assert_ab_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(samp_a && samp_b));

   assert_a_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      samp_a |=> !samp_a);

   assert_b_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      samp_b |=> !samp_b);

   assert_dump_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dump |-> !(samp_a || samp_b));

   assert_dump_two_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $rose(dump)) |=> dump);

   assert_dump_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && dump && $past(dump)) |=> !dump);

   assert_md_then_zclk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mdclk |=> zclk);

   if (!REG_OUT) begin : g_pos_chk
      assert_thr_position_R8: assert property (@(posedge clk) disable iff (!rst_n)
         thr_strb |-> (cell_cnt == CW'(THR_AT)));
   end

   assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && !$past(boundary)) |-> $stable(mode));

   assert_gbd_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> (gbd_out == $past(gbd_in)));
endmodule

bind servo_cell_timer sct_checker #(
   .CELL_LEN (CELL_LEN),
   .THR_AT   (THR_AT),
   .REG_OUT  (REG_OUT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cell_start (cell_start),
   .gbd_in     (gbd_in),
   .samp_a     (samp_a),
   .samp_b     (samp_b),
   .dump       (dump),
   .zclk       (zclk),
   .thr_strb   (thr_strb),
   .mdclk      (mdclk),
   .gbd_out    (gbd_out),
   .cell_cnt   (cell_cnt),
   .boundary   (boundary),
   .mode       (mode)
);

// File: tb/servo_cell_timer_tb.sv
module servo_cell_timer_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cell_start = 1'b0;
   logic gb_en = 1'b0, quad_sel = 1'b0, lsb_in = 1'b0, gbd_in = 1'b0;
   logic samp_a, samp_b, dump, zclk, thr_strb, mdclk, gbd_out;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [6:0] exp_q[$];
   string      tag_q[$];
   logic [2:0] cur_mode = 3'b000;   // {gb, quad, swap}
   logic       prev_gbd = 1'b0;
   int         gbd_seed = 5;

   always #4 clk = ~clk;   // 125 MHz

   servo_cell_timer u_dut (
      .clk(clk), .rst_n(rst_n), .cell_start(cell_start),
      .gb_en(gb_en), .quad_sel(quad_sel), .lsb_in(lsb_in), .gbd_in(gbd_in),
      .samp_a(samp_a), .samp_b(samp_b), .dump(dump), .zclk(zclk),
      .thr_strb(thr_strb), .mdclk(mdclk), .gbd_out(gbd_out)
   );

   // Expected {samp_a, samp_b, dump, zclk, thr, mdclk} from R2..R8
   function automatic logic [5:0] expect_strobes(logic [2:0] m, int i);
      int a_at = m[1] ? 7 : 3;
      int b_at = m[1] ? 11 : 7;
      logic a = m[0] ? (i == b_at) : (i == a_at);
      logic b = m[0] ? (i == a_at) : (i == b_at);
      logic d = (i == 13) || (i == 14);
      logic z = (i == 0) || (m[2] && (i == 8));
      return {a, b, d, z, (i == 5), (i == 15)};
   endfunction

   // Driver: one cell of len cycles under cur_mode, then nxt captured
   task automatic run_cell(logic [2:0] nxt, int len, string tag);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         exp_q.push_back({expect_strobes(cur_mode, i), prev_gbd});
         tag_q.push_back(tag);
         gbd_seed = (gbd_seed * 37 + 11) % 101;
         gbd_in   = gbd_seed[0];
         prev_gbd = gbd_in;
         if (i == len - 1) begin
            {gb_en, quad_sel, lsb_in} = nxt;
            cell_start = (len < 16);
         end else begin
            // R9: mid-cell changes must be ignored
            {gb_en, quad_sel, lsb_in} = 3'(i) ^ nxt;
            cell_start = 1'b0;
         end
      end
      cur_mode = nxt;
   endtask

   // Monitor: pops and compares away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [6:0] e = exp_q.pop_front();
            string      t = tag_q.pop_front();
            logic [6:0] a = {samp_a, samp_b, dump, zclk, thr_strb, mdclk, gbd_out};
            checks++;
            if (a !== e) begin
               fails++;
               $display("FAIL %s (strobes R5 R6 R7 R8, flag R10): actual %b expected %b",
                        t, a, e);
            end
         end
      end
   end

   initial begin
      #40000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      // R11: outputs low during reset
      repeat (3) @(negedge clk);
      gbd_in = 1'b1;
      @(negedge clk);
      #1;
      checks++;
      if ({samp_a, samp_b, dump, zclk, thr_strb, mdclk, gbd_out} !== 7'b0) begin
         fails++;
         $display("FAIL R11 reset: actual %b expected 0000000",
                  {samp_a, samp_b, dump, zclk, thr_strb, mdclk, gbd_out});
      end
      gbd_in = 1'b0;
      @(posedge clk);
      #2 rst_n = 1'b1;

      run_cell(3'b010, 16, "R11 R2 first cell in-phase");
      run_cell(3'b001, 16, "R3 quad");
      run_cell(3'b011, 16, "R4 in-phase swapped");
      run_cell(3'b100, 16, "R4 quad swapped");
      run_cell(3'b110, 16, "R7 guard-band in-phase");
      run_cell(3'b000, 6,  "R7 guard-band quad cut by R1 start");
      run_cell(3'b101, 10, "R1 restart normal");
      run_cell(3'b000, 4,  "R9 guard-band swap short");
      run_cell(3'b000, 16, "R1 R9 normal after restart");
      run_cell(3'b000, 16, "R8 normal steady");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule